// File: doc/BRIEF.md
# Sync Frame Permanence Buffer

This block sits between the stage that screens incoming synchronization control frames and the clock synchronization state machine of a time-triggered Ethernet node. Every frame reaching it has already been screened for semantic errors. Each frame arrives with a receive timestamp taken from the local clock and a transparent-clock field. That field holds the delay the network has already added to the frame. The block keeps each frame back until the frame's total age equals a configured maximum transparent-clock value. It then passes the frame on, tagged with its permanence timestamp. Because every frame becomes permanent at the same age, the network jitter is hidden from the state machine downstream.

The block has one storage slot for each synchronization master index. The permanence timestamp is `rx_ts + max_tc - tc`, computed modulo 2^TS_W. A frame whose transparent-clock field is larger than the configured maximum cannot be held for a negative time. Such a frame is released at once and raises a sticky error flag. Frames that become due together leave in ascending master index order, one per cycle, through a valid/ready output stage. The local clock enters the block as a free-running counter input.

Top module: `sync_perm_buffer`

## Requirements
- R1: After reset, `out_valid_o`, `ovw_flag_o` and `tc_err_o` are all 0.
- R2: A frame accepted with `in_tc_i <= max_tc_i` gets the permanence timestamp `in_rx_ts_i + max_tc_i - in_tc_i` (mod 2^TS_W). It enters the output stage at the first clock edge where its slot is occupied, `now_i - perm_ts` (mod 2^TS_W) has its top bit clear, and the output stage is empty or handing off. `out_valid_o` rises right after that edge.
- R3: A frame is never moved out of its slot before it is due in the sense of R2 (or forced in the sense of R4).
- R4: A frame with `in_tc_i > max_tc_i` is due one edge after it is accepted. Its permanence timestamp is `in_rx_ts_i`, and it sets `tc_err_o` at the edge where it is accepted.
- R5: Each master index `m` (0 to N_MASTERS-1) has exactly one slot. A new frame for `m` replaces the pending one. If the old frame was still pending and was not handed to the output stage at that same edge, `ovw_flag_o` is set.
- R6: When several slots are due at the same edge, the lowest master index is taken first. The remaining frames follow one per cycle while `out_ready_i` is 1.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, all output fields and `out_valid_o` stay unchanged.
- R8: `ovw_flag_o` and `tc_err_o` stay at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | TS_W | Local clock counter |
| max_tc_i | input | TC_W | Configured maximum transparent-clock value |
| in_valid_i | input | 1 | Screened frame present this cycle |
| in_master_i | input | IDX_W | Sending master index |
| in_type_i | input | TYPE_W | Frame type code, passed through unchanged |
| in_rx_ts_i | input | TS_W | Local receive timestamp |
| in_tc_i | input | TC_W | Accumulated transparent-clock delay |
| in_memb_i | input | MEMB_W | Membership vector, passed through unchanged |
| out_ready_i | input | 1 | Downstream accepts the output frame |
| out_valid_o | output | 1 | Permanent frame on the output |
| out_master_o | output | IDX_W | Master index of the output frame |
| out_type_o | output | TYPE_W | Frame type of the output frame |
| out_perm_ts_o | output | TS_W | Permanence timestamp of the output frame |
| out_memb_o | output | MEMB_W | Membership vector of the output frame |
| ovw_flag_o | output | 1 | Sticky pending-frame overwrite flag |
| tc_err_o | output | 1 | Sticky over-range transparent-clock flag |

## Verification
A frame written at edge E occupies its slot after E. The due test is evaluated at E+1 at the earliest, using `now_i` as seen at that edge, so `out_valid_o` can be high no sooner than the cycle after E+1. The flags become visible right after the accepting edge E. The bench runs a reference model at each rising edge on the same input values and compares every output at the following falling edge, so each result is checked in the cycle it is due. Directed checks of release order, timestamps and flag persistence are made a fixed number of falling edges after each stimulus. That count always covers the two-edge path.

// File: rtl/spb_pkg.sv
package spb_pkg;

    typedef struct packed {
        logic ovw;
        logic err;
    } spb_flags_t;

    function automatic logic age_reached(input logic [63:0] diff, input int unsigned width);
        return ~diff[width-1];
    endfunction

endpackage

// File: rtl/spb_slot.sv
module spb_slot #(
    parameter int TS_W   = 32,
    parameter int TYPE_W = 4,
    parameter int MEMB_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now_i,
    input  logic              wr_i,
    input  logic              wr_forced_i,
    input  logic [TS_W-1:0]   wr_perm_i,
    input  logic [TYPE_W-1:0] wr_type_i,
    input  logic [MEMB_W-1:0] wr_memb_i,
    input  logic              pop_i,
    output logic              due_o,
    output logic [TS_W-1:0]   perm_o,
    output logic [TYPE_W-1:0] type_o,
    output logic [MEMB_W-1:0] memb_o,
    output logic              ovw_o
);
    typedef struct packed {
        logic              full;
        logic              forced;
        logic [TS_W-1:0]   perm;
        logic [TYPE_W-1:0] typ;
        logic [MEMB_W-1:0] memb;
    } slot_t;

    slot_t s_d, s_q;
    logic [TS_W-1:0] age;

    always_comb begin
        s_d = s_q;
        if (pop_i) begin
            s_d.full = 1'b0;
        end
        if (wr_i) begin
            s_d.full   = 1'b1;
            s_d.forced = wr_forced_i;
            s_d.perm   = wr_perm_i;
            s_d.typ    = wr_type_i;
            s_d.memb   = wr_memb_i;
        end
        age   = now_i - s_q.perm;
        due_o = s_q.full && (s_q.forced || spb_pkg::age_reached(64'(age), TS_W));
        ovw_o = wr_i && s_q.full && !pop_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign perm_o = s_q.perm;
    assign type_o = s_q.typ;
    assign memb_o = s_q.memb;

    assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> s_q.full);

    assert_pop_only_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> due_o);

endmodule

// File: rtl/spb_pick.sv
module spb_pick #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IDX_W'(i);
                any_o      = 1'b1;
            end
        end
    end

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_in_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

endmodule

// File: rtl/sync_perm_buffer.sv
module sync_perm_buffer #(
    parameter int N_MASTERS = 4,
    parameter int TS_W      = 32,
    parameter int TC_W      = 24,
    parameter int TYPE_W    = 4,
    parameter int MEMB_W    = 16,
    localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now_i,
    input  logic [TC_W-1:0]   max_tc_i,
    input  logic              in_valid_i,
    input  logic [IDX_W-1:0]  in_master_i,
    input  logic [TYPE_W-1:0] in_type_i,
    input  logic [TS_W-1:0]   in_rx_ts_i,
    input  logic [TC_W-1:0]   in_tc_i,
    input  logic [MEMB_W-1:0] in_memb_i,
    input  logic              out_ready_i,
    output logic              out_valid_o,
    output logic [IDX_W-1:0]  out_master_o,
    output logic [TYPE_W-1:0] out_type_o,
    output logic [TS_W-1:0]   out_perm_ts_o,
    output logic [MEMB_W-1:0] out_memb_o,
    output logic              ovw_flag_o,
    output logic              tc_err_o
);
    import spb_pkg::*;

    typedef struct packed {
        logic              ov;
        logic [IDX_W-1:0]  om;
        logic [TYPE_W-1:0] ot;
        logic [TS_W-1:0]   op;
        logic [MEMB_W-1:0] omemb;
        spb_flags_t        flags;
    } top_t;

    top_t t_d, t_q;

    logic                  over_range;
    logic [TS_W-1:0]       entry_perm;
    logic [N_MASTERS-1:0]  wr_vec, due_vec, grant_vec, pop_vec, ovw_vec;
    logic [IDX_W-1:0]      pick_idx;
    logic                  pick_any;
    logic                  load;
    logic [TS_W-1:0]       sl_perm [N_MASTERS];
    logic [TYPE_W-1:0]     sl_type [N_MASTERS];
    logic [MEMB_W-1:0]     sl_memb [N_MASTERS];

    assign over_range = in_tc_i > max_tc_i;
    assign entry_perm = over_range ? in_rx_ts_i
                                   : in_rx_ts_i + TS_W'(max_tc_i) - TS_W'(in_tc_i);
    assign load       = !t_q.ov || out_ready_i;
    assign pop_vec    = grant_vec & {N_MASTERS{load}};

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_slot
        assign wr_vec[g] = in_valid_i && (in_master_i == IDX_W'(g));
        spb_slot #(.TS_W(TS_W), .TYPE_W(TYPE_W), .MEMB_W(MEMB_W)) slot_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .now_i       (now_i),
            .wr_i        (wr_vec[g]),
            .wr_forced_i (over_range),
            .wr_perm_i   (entry_perm),
            .wr_type_i   (in_type_i),
            .wr_memb_i   (in_memb_i),
            .pop_i       (pop_vec[g]),
            .due_o       (due_vec[g]),
            .perm_o      (sl_perm[g]),
            .type_o      (sl_type[g]),
            .memb_o      (sl_memb[g]),
            .ovw_o       (ovw_vec[g])
        );
    end

    spb_pick #(.N(N_MASTERS)) pick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (due_vec),
        .grant_o (grant_vec),
        .idx_o   (pick_idx),
        .any_o   (pick_any)
    );

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.ov = pick_any;
            if (pick_any) begin
                t_d.om    = pick_idx;
                t_d.ot    = sl_type[pick_idx];
                t_d.op    = sl_perm[pick_idx];
                t_d.omemb = sl_memb[pick_idx];
            end
        end
        if (|ovw_vec) begin
            t_d.flags.ovw = 1'b1;
        end
        if (in_valid_i && over_range) begin
            t_d.flags.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign out_valid_o   = t_q.ov;
    assign out_master_o  = t_q.om;
    assign out_type_o    = t_q.ot;
    assign out_perm_ts_o = t_q.op;
    assign out_memb_o    = t_q.omemb;
    assign ovw_flag_o    = t_q.flags.ovw;
    assign tc_err_o      = t_q.flags.err;

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_master_o)
            && $stable(out_perm_ts_o) && $stable(out_type_o) && $stable(out_memb_o)));

    assert_ovw_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_flag_o |=> ovw_flag_o);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_err_o |=> tc_err_o);

    assert_err_on_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && (in_tc_i > max_tc_i)) |=> tc_err_o);

endmodule

// File: tb/sync_perm_buffer_tb_top.sv
module sync_perm_buffer_tb_top;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] now = 32'd100;
    logic [23:0] max_tc = 24'd20;
    logic        in_valid = 1'b0;
    logic [1:0]  in_master = '0;
    logic [3:0]  in_type = '0;
    logic [31:0] in_rx = '0;
    logic [23:0] in_tc = '0;
    logic [15:0] in_memb = '0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [1:0]  out_master;
    logic [3:0]  out_type;
    logic [31:0] out_perm;
    logic [15:0] out_memb;
    logic        ovw_flag, tc_err;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(negedge clk) now <= now + 32'd1;

    sync_perm_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .now_i(now), .max_tc_i(max_tc),
        .in_valid_i(in_valid), .in_master_i(in_master), .in_type_i(in_type),
        .in_rx_ts_i(in_rx), .in_tc_i(in_tc), .in_memb_i(in_memb),
        .out_ready_i(out_ready), .out_valid_o(out_valid), .out_master_o(out_master),
        .out_type_o(out_type), .out_perm_ts_o(out_perm), .out_memb_o(out_memb),
        .ovw_flag_o(ovw_flag), .tc_err_o(tc_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    bit          m_full [N];
    bit          m_forced [N];
    logic [31:0] m_perm [N];
    logic [3:0]  m_type [N];
    logic [15:0] m_memb [N];
    bit          m_ov, m_ovw, m_err;
    int          m_om;
    logic [3:0]  m_ot;
    logic [31:0] m_op;
    logic [15:0] m_omemb;
    int          rel_m[$];
    logic [31:0] rel_p[$];
    logic [15:0] rel_memb[$];

    always @(posedge clk) begin
        int pick;
        bit load;
        int w;
        logic [31:0] d;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_full[i] = 1'b0;
            m_ov = 1'b0; m_ovw = 1'b0; m_err = 1'b0;
        end else begin
            if (out_valid && out_ready) begin
                rel_m.push_back(int'(out_master));
                rel_p.push_back(out_perm);
                rel_memb.push_back(out_memb);
            end
            pick = -1;
            for (int i = N - 1; i >= 0; i--) begin
                d = now - m_perm[i];
                if (m_full[i] && (m_forced[i] || !d[31])) pick = i;
            end
            load = !m_ov || out_ready;
            w = int'(in_master);
            if (in_valid && m_full[w] && !(load && pick == w)) m_ovw = 1'b1;
            if (in_valid && in_tc > max_tc) m_err = 1'b1;
            if (load) begin
                m_ov = (pick >= 0);
                if (pick >= 0) begin
                    m_om = pick; m_ot = m_type[pick]; m_op = m_perm[pick];
                    m_omemb = m_memb[pick]; m_full[pick] = 1'b0;
                end
            end
            if (in_valid) begin
                m_full[w]   = 1'b1;
                m_forced[w] = (in_tc > max_tc);
                m_perm[w]   = (in_tc > max_tc) ? in_rx : in_rx + 32'(max_tc) - 32'(in_tc);
                m_type[w]   = in_type;
                m_memb[w]   = in_memb;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_valid == m_ov, "R2", "out_valid", out_valid, m_ov);
            if (m_ov) begin
                chk(int'(out_master) == m_om, "R6", "out_master", out_master, m_om);
                chk(out_perm == m_op, "R2", "out_perm_ts", out_perm, m_op);
                chk(out_type == m_ot, "R7", "out_type", out_type, m_ot);
                chk(out_memb == m_omemb, "R5", "out_memb", out_memb, m_omemb);
            end
            chk(ovw_flag == m_ovw, "R5", "ovw_flag", ovw_flag, m_ovw);
            chk(tc_err == m_err, "R4", "tc_err", tc_err, m_err);
        end
    end

    task automatic send(input int m, input logic [3:0] t, input logic [31:0] rx,
                        input logic [23:0] tc, input logic [15:0] mb);
        in_valid = 1'b1; in_master = 2'(m); in_type = t;
        in_rx = rx; in_tc = tc; in_memb = mb;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] r;
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !ovw_flag && !tc_err, "R1", "outputs after reset",
            {out_valid, ovw_flag, tc_err}, 0);

        // R2: hold time is max minus recorded delay
        r = now;
        send(2, 4'd1, r, 24'd5, 16'h0004);
        idle(30);
        chk(rel_m.size() == 1 && rel_m[0] == 2, "R2", "release of master 2", rel_m.size(), 1);
        chk(rel_p[0] == r + 32'd15, "R2", "perm ts tc=5", rel_p[0], r + 32'd15);

        // R2 boundary: tc equal to max, no error
        r = now;
        send(1, 4'd2, r, 24'd20, 16'h0002);
        idle(6);
        chk(rel_p[1] == r, "R2", "perm ts tc=max", rel_p[1], r);
        chk(tc_err == 1'b0, "R2", "no error at tc=max", tc_err, 0);

        // R4: over-range delay is released at once
        r = now + 32'd50;
        send(3, 4'd3, r, 24'd25, 16'h0008);
        idle(2);
        chk(rel_m.size() == 3, "R4", "forced release count", rel_m.size(), 3);
        chk(rel_p[2] == r, "R4", "forced perm ts", rel_p[2], r);
        chk(tc_err == 1'b1, "R4", "error flag", tc_err, 1);

        // R5: overwrite of a pending frame
        r = now;
        send(0, 4'd1, r, 24'd0, 16'h00A1);
        send(0, 4'd1, r + 32'd1, 24'd0, 16'h00B2);
        idle(1);
        chk(ovw_flag == 1'b1, "R5", "overwrite flag", ovw_flag, 1);
        idle(30);
        chk(rel_m.size() == 4 && rel_memb[3] == 16'h00B2, "R5", "only newest frame released",
            rel_memb[3], 16'h00B2);

        // R6: same permanence time, written in descending order
        r = now;
        for (int k = 3; k >= 0; k--) send(k, 4'd4, r, 24'd0, 16'(k));
        idle(30);
        for (int k = 0; k < 4; k++) begin
            chk(rel_m[4 + k] == k, "R6", "ascending release order", rel_m[4 + k], k);
            chk(rel_p[4 + k] == r + 32'd20, "R6", "shared perm ts", rel_p[4 + k], r + 32'd20);
        end

        // R7: back-pressure keeps the output steady
        out_ready = 1'b0;
        r = now;
        send(2, 4'd5, r, 24'd3, 16'h0200);
        send(1, 4'd6, r, 24'd3, 16'h0100);
        idle(30);
        chk(out_valid && out_master == 2'd1, "R7", "held output master", out_master, 1);
        idle(5);
        chk(out_valid && out_master == 2'd1 && out_perm == r + 32'd17, "R7",
            "output unchanged while stalled", out_perm, r + 32'd17);
        out_ready = 1'b1;
        idle(5);
        chk(rel_m.size() == 10 && rel_m[9] == 2, "R7", "drain after stall", rel_m.size(), 10);

        // R8: flags persist
        idle(10);
        chk(ovw_flag && tc_err, "R8", "sticky flags", {ovw_flag, tc_err}, 3);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 20000, 0);
        finish_run();
    end

endmodule